// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous host and an external asynchronous static RAM with a byte-wide bidirectional data bus. The host presents one request at a time on a valid/ready port: a write carries an address and a data byte, and a read returns a byte with a one-cycle valid pulse. The controller turns each request into a correctly ordered sequence of memory strobes. These are a low-active chip enable, a high-active chip enable, a low-active output enable and a low-active write enable. Every strobe comes from a flip-flop.

The length of each access is fixed in system clock cycles by three parameters: `READ_CYC` for the read access, `WR_PULSE` for the write strobe and `TURN` for the quiet gap that follows every access. They are rounded up from the memory's nanosecond figures, which lets one design serve any speed grade. The address changes only in the same edge that enables the chip, and it stays put until the chip is disabled. The controller drives write data for one cycle before the write strobe falls and releases the bus in the same edge at which the strobe rises. It never drives while output enable is low. Between requests the memory is held in standby.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the memory is in standby: low-active enable high, high-active enable low, output enable high and write enable high. In the same window req_ready is 1 and rdata_valid is 0.
- R2: Whenever no access is in progress, the memory is held in standby with output enable and write enable high.
- R3: req_ready is 1 only in the idle state. A request is taken when req_valid and req_ready are both 1 at a clock edge. Host inputs that change while an access is in progress have no effect on the memory address or on the strobes.
- R4: A read holds both chip enables active, output enable low and write enable high for exactly READ_CYC cycles, starting in the cycle after the request is taken. The address equals the requested address throughout.
- R5: A read returns the byte the memory drives at the end of its last access cycle. The byte appears on rdata with rdata_valid high for exactly one cycle, READ_CYC cycles after the request is taken.
- R6: A write first spends one cycle with both chip enables active, write enable high and the data driven. Write enable is then low for exactly WR_PULSE cycles. Address and data stay stable from the enabling edge until the chip is disabled.
- R7: Output enable and write enable are never low together, and the controller never drives the data bus while output enable is low.
- R8: After every access the memory sits in standby with req_ready at 0 for exactly TURN cycles before req_ready returns to 1.
- R9: A byte written to an address is returned by any later read of that address, as long as no write to that address comes in between.
- R10: rdata_valid never pulses as the result of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_we | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Byte to write |
| rdata | output | DATA_W | Byte returned by the last read |
| rdata_valid | output | 1 | One-cycle pulse marking new rdata |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq | inout | DATA_W | Memory bidirectional data bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_ce2 | output | 1 | Memory chip enable, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
The bench builds the controller with a 6-bit address and an 8-bit data bus. It sets READ_CYC to 3, WR_PULSE to 2 and TURN to 2, so every one of the 64 locations can be written and read back with a behavioural memory model. Because TURN is 2, there is room to check both the one-cycle valid pulse and the turnaround gap on their own cycles. The two write passes use different data patterns and run in opposite address orders, which exposes stale data and address aliasing. Each access is checked cycle by cycle against a schedule computed from the three parameters. The host address is scrambled while every access is in flight.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSET = 3'd2,
    ST_WPUL = 3'd3,
    ST_TURN = 3'd4
  } sc_state_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int READ_CYC = 3,
  parameter int WR_PULSE = 3,
  parameter int TURN     = 1,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             ce_n,
  output logic             ce2,
  output logic             oe_n,
  output logic             we_n,
  output logic             drv_en
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] TN_LOAD = CNT_W'(TURN - 1);

  sc_state_t st, ns;
  logic      ns_active;

  always_comb begin
    ns       = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_we) begin
            ns = ST_WSET;
          end else begin
            ns       = ST_RD;
            tmr_load = 1'b1;
            tmr_val  = RD_LOAD;
          end
        end
      end
      ST_RD: begin
        if (tmr_done) begin
          ns       = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = TN_LOAD;
        end
      end
      ST_WSET: begin
        ns       = ST_WPUL;
        tmr_load = 1'b1;
        tmr_val  = WP_LOAD;
      end
      ST_WPUL: begin
        if (tmr_done) begin
          ns       = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = TN_LOAD;
        end
      end
      ST_TURN: begin
        if (tmr_done)
          ns = ST_IDLE;
      end
      default: ns = ST_IDLE;
    endcase
  end

  assign ns_active = (ns == ST_RD) || (ns == ST_WSET) || (ns == ST_WPUL);
  assign ready     = (st == ST_IDLE);
  assign accept    = ready && req_valid;
  assign capture   = (st == ST_RD) && tmr_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ce_n   <= 1'b1;
      ce2    <= 1'b0;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      drv_en <= 1'b0;
    end else begin
      st     <= ns;
      ce_n   <= !ns_active;
      ce2    <= ns_active;
      oe_n   <= (ns != ST_RD);
      we_n   <= (ns != ST_WPUL);
      drv_en <= (ns == ST_WSET) || (ns == ST_WPUL);
    end
  end

endmodule

// File: rtl/sram_ctl_dqio.sv
module sram_ctl_dqio #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture)
        rdata_q <= dq_in;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int READ_CYC = 3,
  parameter int WR_PULSE = 3,
  parameter int TURN     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  localparam int MAX_CYC = int'(max3(READ_CYC, WR_PULSE, TURN));
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             tmr_load, tmr_done, accept, capture, drv_en;
  logic [CNT_W-1:0] tmr_val;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] dq_in;

  sram_ctl_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_ctl_fsm #(
    .READ_CYC (READ_CYC),
    .WR_PULSE (WR_PULSE),
    .TURN     (TURN),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_we    (req_we),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .capture   (capture),
    .ready     (req_ready),
    .ce_n      (mem_ce_n),
    .ce2       (mem_ce2),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .drv_en    (drv_en)
  );

  sram_ctl_dqio #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dqio (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (dq_in),
    .addr_q    (mem_addr),
    .wdata_q   (wdata_q),
    .rdata_q   (rdata),
    .rvalid_q  (rdata_valid)
  );

  assign mem_dq = drv_en ? wdata_q : {DATA_W{1'bz}};
  assign dq_in  = mem_dq;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rdata_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              drv_en
);

  AST_RESET_STANDBY: assert property (@(posedge clk)
    rst |=> (mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !rdata_valid && req_ready)); // R1

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n)); // R2

  AST_ACCEPT_ENABLES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!mem_ce_n && mem_ce2 && !req_ready)); // R3

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |=> !rdata_valid); // R5

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |-> $past(!mem_oe_n)); // R5

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_ce2 && drv_en)); // R6

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n)); // R7

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> mem_oe_n); // R7

  AST_CE_PAIR: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n != mem_ce2); // R2

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rdata_valid (rdata_valid),
  .mem_addr    (mem_addr),
  .mem_ce_n    (mem_ce_n),
  .mem_ce2     (mem_ce2),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .drv_en      (drv_en)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int RC = 3;
  localparam int WP = 2;
  localparam int TN = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rdata_valid;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;
  logic          mem_ce_n, mem_ce2, mem_oe_n, mem_we_n;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] expm  [DEPTH];

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sram_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .READ_CYC(RC), .WR_PULSE(WP), .TURN(TN)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rdata(rdata), .rdata_valid(rdata_valid), .mem_addr(mem_addr),
    .mem_dq(mem_dq), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  // behavioural memory: drives on read, stores while the write strobe is low
  wire chip_on = !mem_ce_n && mem_ce2;
  assign mem_dq = (chip_on && !mem_oe_n && mem_we_n) ? model[mem_addr] : {DW{1'bz}};

  always @(negedge clk)
    if (chip_on && !mem_we_n) model[mem_addr] <= mem_dq;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit standby();
    return mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n;
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'((a * 37 + s * 91 + 5) & 8'hFF);
  endfunction

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_wdata = ~d;
    req_we    = ~we;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1'b1, a, d);
    expm[a] = d;
    check(chip_on && mem_we_n && mem_oe_n, "R6 setup", {mem_ce_n, mem_ce2, mem_we_n}, 3'b011);
    check(mem_addr == a, "R6 addr", mem_addr, a);
    check(!req_ready, "R3 busy", req_ready, 0);
    for (int k = 1; k <= WP; k++) begin
      @(negedge clk);
      check(chip_on && !mem_we_n, "R6 strobe", mem_we_n, 0);
      check(mem_oe_n, "R7 oe", mem_oe_n, 1);
      check(mem_addr == a, "R3 addr held", mem_addr, a);
    end
    for (int k = 0; k < TN; k++) begin
      @(negedge clk);
      check(standby(), "R8 turn", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b1011);
      check(!req_ready, "R8 busy", req_ready, 0);
      check(!rdata_valid, "R10", rdata_valid, 0);
    end
    @(negedge clk);
    check(req_ready, "R8 ready", req_ready, 1);
    check(!rdata_valid, "R10 end", rdata_valid, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    issue(1'b0, a, 8'h00);
    for (int k = 0; k < RC; k++) begin
      if (k > 0) @(negedge clk);
      check(chip_on && !mem_oe_n && mem_we_n, "R4 strobes", {mem_oe_n, mem_we_n}, 2'b01);
      check(mem_addr == a, "R4 addr", mem_addr, a);
      check(!rdata_valid, "R5 early", rdata_valid, 0);
    end
    @(negedge clk);
    check(rdata_valid, "R5 valid", rdata_valid, 1);
    check(rdata == expm[a], "R9 data", rdata, expm[a]);
    check(standby(), "R8 release", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b1011);
    for (int k = 1; k < TN; k++) begin
      @(negedge clk);
      check(!rdata_valid, "R5 pulse", rdata_valid, 0);
      check(!req_ready, "R8 busy", req_ready, 0);
    end
    @(negedge clk);
    check(req_ready, "R8 ready", req_ready, 1);
    check(!rdata_valid, "R5 end", rdata_valid, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(standby(), "R1 standby", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b1011);
    check(req_ready && !rdata_valid, "R1 flags", {req_ready, rdata_valid}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    check(standby(), "R1 after", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b1011);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(standby() && req_ready, "R2 idle", {mem_ce_n, mem_ce2, req_ready}, 3'b101);
    end
    for (int a = 0; a < DEPTH; a++) do_write(AW'(a), pat(a, 0));
    for (int a = 0; a < DEPTH; a++) do_read(AW'(a));
    for (int a = DEPTH - 1; a >= 0; a--) do_write(AW'(a), ~pat(a, 1));
    for (int a = DEPTH - 1; a >= 0; a--) do_read(AW'(a));
    do_write(AW'(5), 8'h00);
    do_write(AW'(5), 8'hFF);
    do_read(AW'(5));
    do_read(AW'(5));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(standby(), "R2 final", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b1011);
    end
    finish_run();
  end

  initial begin
    #(200000 * 5);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

endmodule